// File: doc/BRIEF.md
# NOR-style byte storage array with program and erase

This block holds a byte-addressed array that behaves like NOR flash. A byte program can only clear bits: the stored byte becomes the old value ANDed with the new one. When the overwrite mode pin is high, the new byte replaces the old one, as an EEPROM would. Erase requests name a region kind and an offset. The block aligns the offset down to the region size and fills the region with 0xFF, one byte per clock, while `busy` is high.

The three request ports (erase, program, read) use valid/ready. A request is taken on a rising edge where valid and ready are both high. While an erase runs, every ready is low, so the requester must hold its request until ready returns. When idle, one request is taken per cycle, with erase first, then program, then read. Read data comes back on a plain `rd_dvalid`/`rd_data` pair one cycle after the read is taken, with no back-pressure. A level-sensitive write-enable input gates erases. Parameters select which of the two smaller erase kinds the device supports. Error and diagnostic outputs are one-cycle pulses.

Top module: `flash_array`

## Requirements
- R1: After reset every byte reads 0xFF, and `busy`, `rd_dvalid`, `err_protect`, `err_cap` and `zero_to_one` are 0.
- R2: With `overwrite_mode` low, a taken program stores old AND `pg_data`.
- R3: With `overwrite_mode` high, a taken program stores `pg_data` unchanged and never raises `zero_to_one`.
- R4: A program taken while `wen` is low still updates the byte and pulses `err_protect` for one cycle, in the cycle after it is taken.
- R5: With `overwrite_mode` low, a program whose data has a 1 where the stored byte has a 0 pulses `zero_to_one` in the cycle after it is taken.
- R6: `er_kind` encodes the region: 0 = small (SMALL_BYTES), 1 = mid (MID_BYTES), 2 = sector (SECTOR_BYTES). The region base is `er_addr` aligned down to the region size. Only bytes from base to base+size-1 become 0xFF.
- R7: An accepted erase raises `busy` in the next cycle. `busy` stays high for exactly as many cycles as the region has bytes, and one byte is written per clock.
- R8: An erase taken while `wen` is low changes no byte, leaves `busy` low and pulses `err_protect` in the next cycle.
- R9: An erase of a kind whose capability parameter is 0 pulses `err_cap` in the next cycle, and the erase is still performed if `wen` is high.
- R10: While `busy` is high, `er_ready`, `pg_ready` and `rd_ready` are 0. When idle, `er_ready` is 1, `pg_ready` equals NOT `er_valid`, and `rd_ready` equals NOT (`er_valid` OR `pg_valid`).
- R11: A taken read gives `rd_dvalid` high for exactly the next cycle, with `rd_data` holding the stored byte.
- R12: `er_kind` 3 erases the whole array from address 0, whatever the value of `er_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wen | input | 1 | Write-enable level |
| overwrite_mode | input | 1 | 1: program replaces the byte |
| er_valid | input | 1 | Erase request valid |
| er_ready | output | 1 | Erase request ready |
| er_kind | input | 2 | Region kind (R6, R12) |
| er_addr | input | AW | Erase offset |
| pg_valid | input | 1 | Program request valid |
| pg_ready | output | 1 | Program request ready |
| pg_addr | input | AW | Program address |
| pg_data | input | 8 | Program byte |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | AW | Read address |
| rd_dvalid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Erase in progress |
| err_protect | output | 1 | Write-enable violation pulse |
| err_cap | output | 1 | Unsupported erase kind pulse |
| zero_to_one | output | 1 | Attempted 0-to-1 program pulse |

## Verification
The tests program bytes in several ways and compare each result. Overlapping programs show AND merging against plain replacement. A program over a cleared bit tells the diagnostic flag apart from a normal clear. A program with write-enable low separates the error flag from the data path. Test bytes sit just inside and just outside each erase region, which exposes a wrong alignment or a wrong length. Reads held during an erase and three requests raised in the same cycle check the stall and the priority. An erase with write-enable low and an erase of an unsupported kind show the two error outcomes: the first is dropped, the second is performed.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    ER_SMALL  = 2'd0,
    ER_MID    = 2'd1,
    ER_SECTOR = 2'd2,
    ER_WHOLE  = 2'd3
  } er_kind_t;

  localparam logic [7:0] BLANK = 8'hFF;
endpackage

// File: rtl/flash_merge.sv
module flash_merge (
  input  logic       overwrite,
  input  logic       wen,
  input  logic [7:0] old_byte,
  input  logic [7:0] new_byte,
  output logic [7:0] out_byte,
  output logic       raise_hit,
  output logic       protect_hit
);
  always_comb begin
    if (overwrite) begin
      out_byte  = new_byte;
      raise_hit = 1'b0;
    end else begin
      out_byte  = old_byte & new_byte;
      raise_hit = |(new_byte & ~old_byte);
    end
    protect_hit = ~wen;
  end
endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= flash_pkg::BLANK;
      rd_data <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int DEPTH        = 2048,
  parameter int SMALL_BYTES  = 64,
  parameter int MID_BYTES    = 256,
  parameter int SECTOR_BYTES = 512,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic          wen,
  output logic          busy,
  output logic [AW-1:0] cur,
  output logic          err_protect,
  output logic          err_cap
);
  import flash_pkg::*;

  er_kind_t      k;
  logic [CW-1:0] len_sel;
  logic [AW-1:0] base;
  logic [CW-1:0] remain;
  logic          cap_miss;

  assign k = er_kind_t'(kind);

  always_comb begin
    case (k)
      ER_SMALL:  len_sel = CW'(SMALL_BYTES);
      ER_MID:    len_sel = CW'(MID_BYTES);
      ER_SECTOR: len_sel = CW'(SECTOR_BYTES);
      default:   len_sel = CW'(DEPTH);
    endcase
    base = addr & ~(len_sel[AW-1:0] - 1'b1);
  end

  generate
    if (CAP_SMALL && CAP_MID) begin : g_cap_all
      assign cap_miss = 1'b0;
    end else if (CAP_SMALL) begin : g_cap_small
      assign cap_miss = (k == ER_MID);
    end else if (CAP_MID) begin : g_cap_mid
      assign cap_miss = (k == ER_SMALL);
    end else begin : g_cap_none
      assign cap_miss = (k == ER_SMALL) || (k == ER_MID);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur         <= '0;
      remain      <= '0;
      err_protect <= 1'b0;
      err_cap     <= 1'b0;
    end else begin
      err_protect <= start && !wen;
      err_cap     <= start && cap_miss;
      if (busy) begin
        cur    <= cur + 1'b1;
        remain <= remain - 1'b1;
        if (remain == CW'(1)) busy <= 1'b0;
      end else if (start && wen) begin
        busy   <= 1'b1;
        cur    <= base;
        remain <= len_sel;
      end
    end
  end

  // R7
  erase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cur == $past(cur) + 1'b1);
  // R7
  erase_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remain != '0);
  // R8
  erase_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !wen && !busy |=> !busy);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTOR_COUNT = 4,
  parameter int SMALL_BYTES  = 64,
  parameter int MID_BYTES    = 256,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  localparam int DEPTH = SECTOR_BYTES * SECTOR_COUNT,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic          overwrite_mode,
  input  logic          er_valid,
  output logic          er_ready,
  input  logic [1:0]    er_kind,
  input  logic [AW-1:0] er_addr,
  input  logic          pg_valid,
  output logic          pg_ready,
  input  logic [AW-1:0] pg_addr,
  input  logic [7:0]    pg_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_dvalid,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          err_protect,
  output logic          err_cap,
  output logic          zero_to_one
);
  logic          er_fire, pg_fire, rd_fire;
  logic [AW-1:0] er_cur;
  logic          er_prot;
  logic [7:0]    old_byte, mrg_byte;
  logic          raise_hit, protect_hit;
  logic          pg_prot_q, raise_q;
  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [7:0]    st_wdata;

  assign er_ready = !busy;
  assign pg_ready = !busy && !er_valid;
  assign rd_ready = !busy && !er_valid && !pg_valid;
  assign er_fire  = er_valid && er_ready;
  assign pg_fire  = pg_valid && pg_ready;
  assign rd_fire  = rd_valid && rd_ready;

  flash_erase_seq #(
    .DEPTH(DEPTH), .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(er_fire), .kind(er_kind),
    .addr(er_addr), .wen(wen), .busy(busy), .cur(er_cur),
    .err_protect(er_prot), .err_cap(err_cap)
  );

  flash_merge u_merge (
    .overwrite(overwrite_mode), .wen(wen), .old_byte(old_byte),
    .new_byte(pg_data), .out_byte(mrg_byte), .raise_hit(raise_hit),
    .protect_hit(protect_hit)
  );

  assign st_we    = busy || pg_fire;
  assign st_waddr = busy ? er_cur : pg_addr;
  assign st_wdata = busy ? flash_pkg::BLANK : mrg_byte;

  flash_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(st_waddr),
    .wdata(st_wdata), .peek_addr(pg_addr), .peek_data(old_byte),
    .rd_en(rd_fire), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_dvalid <= 1'b0;
      pg_prot_q <= 1'b0;
      raise_q   <= 1'b0;
    end else begin
      rd_dvalid <= rd_fire;
      pg_prot_q <= pg_fire && protect_hit;
      raise_q   <= pg_fire && raise_hit;
    end
  end

  assign err_protect = er_prot || pg_prot_q;
  assign zero_to_one = raise_q;

  // R2
  and_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_fire && !overwrite_mode |-> (mrg_byte & ~old_byte) == 8'h00);
  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_dvalid);
  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_dvalid);
  // R10
  erase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pg_fire && !rd_fire && !er_fire);
  // R3
  overwrite_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_fire && overwrite_mode |=> !zero_to_one);
endmodule

// File: tb/flash_array_tb.sv
`timescale 1ns/1ps
module flash_array_tb;
  localparam int DEPTH = 2048;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen = 1'b0, overwrite_mode = 1'b0;
  logic er_valid = 1'b0, pg_valid = 1'b0, rd_valid = 1'b0;
  logic [1:0] er_kind = '0;
  logic [AW-1:0] er_addr = '0, pg_addr = '0, rd_addr = '0;
  logic [7:0] pg_data = '0;
  logic er_ready, pg_ready, rd_ready, rd_dvalid, busy, err_protect, err_cap, zero_to_one;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  flash_array u_dut (
    .clk(clk), .rst_n(rst_n), .wen(wen), .overwrite_mode(overwrite_mode),
    .er_valid(er_valid), .er_ready(er_ready), .er_kind(er_kind), .er_addr(er_addr),
    .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_addr(pg_addr), .pg_data(pg_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_dvalid(rd_dvalid), .rd_data(rd_data), .busy(busy),
    .err_protect(err_protect), .err_cap(err_cap), .zero_to_one(zero_to_one)
  );

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  // reference model
  logic [7:0] mdl [DEPTH];
  bit m_busy, m_ep, m_ec, m_z, m_rdv;
  int m_cur, m_cnt;
  logic [7:0] m_rdd;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
      m_busy = 0; m_ep = 0; m_ec = 0; m_z = 0; m_rdv = 0; m_cur = 0; m_cnt = 0;
    end else begin
      m_ep = 0; m_ec = 0; m_z = 0; m_rdv = 0;
      if (m_busy) begin
        mdl[m_cur] = 8'hFF; m_cur++; m_cnt--;
        if (m_cnt == 0) m_busy = 0;
      end else if (er_valid) begin
        int len;
        len = (er_kind == 0) ? 64 : (er_kind == 1) ? 256 : (er_kind == 2) ? 512 : DEPTH;
        if (er_kind == 1) m_ec = 1;
        if (!wen) m_ep = 1;
        else begin
          m_busy = 1; m_cnt = len; m_cur = (int'(er_addr) / len) * len;
        end
      end else if (pg_valid) begin
        logic [7:0] old;
        old = mdl[pg_addr];
        if (!wen) m_ep = 1;
        if (overwrite_mode) mdl[pg_addr] = pg_data;
        else begin
          if ((pg_data & ~old) != 0) m_z = 1;
          mdl[pg_addr] = old & pg_data;
        end
      end else if (rd_valid) begin
        m_rdv = 1; m_rdd = mdl[rd_addr];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("busy", busy, m_busy);
      chk("rd_dvalid", rd_dvalid, m_rdv);
      if (m_rdv) chk("rd_data", rd_data, m_rdd);
      chk("err_protect", err_protect, m_ep);
      chk("err_cap", err_cap, m_ec);
      chk("zero_to_one", zero_to_one, m_z);
      chk("er_ready", er_ready, !m_busy);
      chk("pg_ready", pg_ready, !m_busy && !er_valid);
      chk("rd_ready", rd_ready, !m_busy && !er_valid && !pg_valid);
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      summary();
    end
  end

  task automatic do_prog(input int a, input int d);
    @(negedge clk); #1; pg_valid = 1; pg_addr = AW'(a); pg_data = 8'(d);
    @(negedge clk); #1; pg_valid = 0;
  endtask

  task automatic do_read(input int a);
    @(negedge clk); #1; rd_valid = 1; rd_addr = AW'(a);
    @(negedge clk); #1; rd_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_erase(input int k, input int a);
    @(negedge clk); #1; er_valid = 1; er_kind = 2'(k); er_addr = AW'(a);
    @(negedge clk); #1; er_valid = 0;
  endtask

  task automatic wait_idle;
    do @(negedge clk); while (m_busy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk("reset busy", busy, 0);
    chk("reset rd_dvalid", rd_dvalid, 0);
    do_read(0); do_read(5); do_read(2047);

    wen = 1;
    phase = "R2"; do_prog(10, 8'hA5); do_read(10);
    phase = "R5"; do_prog(10, 8'h3C); do_read(10);
    phase = "R2"; do_prog(11, 8'h0F); do_prog(11, 8'hF0); do_read(11);
    phase = "R4"; wen = 0; do_prog(20, 8'h0F); do_read(20); wen = 1;
    phase = "R3"; overwrite_mode = 1; do_prog(10, 8'hFF); do_read(10);
    do_prog(11, 8'h5A); do_read(11); overwrite_mode = 0;

    phase = "R6";
    do_prog(63, 0); do_prog(64, 0); do_prog(127, 0); do_prog(128, 0);
    do_erase(0, 70);
    phase = "R7";
    @(negedge clk); #1; rd_valid = 1; rd_addr = 64; pg_valid = 1; pg_addr = 65;
    repeat (6) @(negedge clk);
    #1; rd_valid = 0; pg_valid = 0;
    wait_idle();
    phase = "R6";
    do_read(63); do_read(64); do_read(127); do_read(128);

    phase = "R9";
    do_prog(255, 0); do_prog(256, 0); do_prog(511, 0); do_prog(512, 0);
    do_erase(1, 300); wait_idle();
    do_read(255); do_read(256); do_read(511); do_read(512);

    phase = "R8";
    do_prog(600, 0); wen = 0;
    do_erase(2, 600); repeat (3) @(negedge clk);
    do_read(600); wen = 1;

    phase = "R10";
    @(negedge clk); #1;
    er_valid = 1; er_kind = 0; er_addr = 0;
    pg_valid = 1; pg_addr = 5; pg_data = 0;
    rd_valid = 1; rd_addr = 5;
    #0.5;
    chk("prio er_ready", er_ready, 1);
    chk("prio pg_ready", pg_ready, 0);
    chk("prio rd_ready", rd_ready, 0);
    @(negedge clk); #1; er_valid = 0; pg_valid = 0; rd_valid = 0;
    wait_idle(); do_read(5); do_read(10);

    phase = "R6";
    do_prog(511, 0); do_prog(1023, 0); do_prog(1024, 0);
    do_erase(2, 1000); wait_idle();
    do_read(511); do_read(512); do_read(1023); do_read(1024);

    phase = "R12";
    do_prog(0, 0); do_prog(2047, 0);
    do_erase(3, 1500); wait_idle();
    do_read(0); do_read(20); do_read(1024); do_read(2047);

    phase = "R11";
    do_read(3);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule